// File: doc/BRIEF.md
# Lane-Parallel Saturating Rounding Shifter

This unit is one stage of a SIMD integer datapath. It splits a packed 128-bit operand into signed lanes of 8, 16, 32 or 64 bits. Each lane is shifted by a signed count taken from the same lane of a second packed operand. A count of zero or more shifts the lane left. A negative count shifts the lane right arithmetically and rounds to nearest. Every result is clamped to the signed range of its lane. The unit reports whether this operation clamped any lane, and it keeps a sticky flag that collects saturation events until software clears it.

The caller picks a vector of 64 or 128 bits, or a scalar mode in which a single element sits in the low bits. One lane-size and width combination is reserved. When it is requested, the unit raises an illegal flag and writes no data. Each operation is accepted on `valid_i`. Its result appears on the registered outputs one clock later and stays there until the next accepted operation.

Top module: `lane_qrshift`

## Requirements
- R1: `size_i` sets the lane width: 00 gives 8 bits, 01 gives 16, 10 gives 32 and 11 gives 64; lanes are packed from bit 0 upward.
- R2: In vector mode (`scalar_i`=0) the active width is 64 bits when `wide_i`=0 and 128 bits when `wide_i`=1; the number of lanes is the active width divided by the lane width.
- R3: Vector mode with `size_i`=11 and `wide_i`=0 is reserved: `illegal_o` goes to 1, `res_o` is all zero, `sat_o` is 0 and `qc_o` keeps its value; any legal operation returns `illegal_o` to 0.
- R4: The shift count of a lane is bits [7:0] of the matching lane of `opb_i`, read as two's complement (-128..127); all higher bits of that lane have no effect.
- R5: A count of zero or more shifts the signed lane value left by that count; a count of zero returns the operand unchanged.
- R6: A negative count -m gives floor((x + 2^(m-1)) / 2^m) computed at full precision, which is a rounding right shift with ties going toward positive infinity.
- R7: A result above the lane maximum becomes 2^(w-1)-1, a result below the lane minimum becomes -2^(w-1), and `sat_o` is 1 exactly when at least one active lane was clamped.
- R8: `qc_o` is set on any operation that reports saturation and stays set until `qc_clr_i` is sampled high; if a clear and a saturating operation arrive in the same cycle, the set wins.
- R9: In scalar mode (`scalar_i`=1) exactly one element of the selected width is processed from the low bits of both operands, and all four sizes are legal.
- R10: When the count magnitude is at or above the lane width, a left shift of a nonzero value saturates, a left shift of zero gives zero, and a right shift gives zero.
- R11: Result bits above the active width are zero, and lanes above the active width never contribute to `sat_o`.
- R12: `res_o`, `sat_o` and `illegal_o` update on the clock edge that samples `valid_i`=1 and hold while `valid_i` is 0; after reset all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Starts an operation on the present inputs |
| opa_i | input | 128 | Packed signed data lanes |
| opb_i | input | 128 | Packed lanes whose low byte is the shift count |
| size_i | input | 2 | Lane width code |
| wide_i | input | 1 | Vector width select: 0 gives 64 bits, 1 gives 128 bits |
| scalar_i | input | 1 | Process a single low element |
| qc_clr_i | input | 1 | Clears the sticky saturation flag |
| res_o | output | 128 | Packed clamped result |
| sat_o | output | 1 | The last operation clamped at least one lane |
| qc_o | output | 1 | Sticky cumulative saturation flag |
| illegal_o | output | 1 | The last operation used the reserved encoding |

## Verification
The properties treat `valid_i` as a level that is sampled at every edge. A held `valid_i` therefore counts as back-to-back operations. The properties also assume the mode inputs are stable across each sampling edge. The stimulus changes every input on the falling edge. It raises `valid_i` for exactly one cycle per operation and pulses `qc_clr_i` only in that same cycle or alone. Data and counts are drawn so that each lane size meets zero counts, counts at or beyond the lane width, the count of -128, and values at both ends of the signed range.

// File: rtl/lqs_pkg.sv
package lqs_pkg;
  localparam int unsigned DATA_W = 128;
  localparam int unsigned CNT_W  = 8;
  localparam int unsigned MIN_LW = 8;
  localparam int unsigned NUM_SZ = 4;
  localparam int unsigned MAX_LW = MIN_LW << (NUM_SZ - 1);

  typedef enum logic [1:0] {
    SZ_8  = 2'b00,
    SZ_16 = 2'b01,
    SZ_32 = 2'b10,
    SZ_64 = 2'b11
  } lane_sz_e;
endpackage

// File: rtl/lqs_lane.sv
module lqs_lane #(
  parameter int unsigned LW = 8,
  parameter int unsigned CW = 8
) (
  input  logic [LW-1:0] val_i,
  input  logic [CW-1:0] cnt_i,
  output logic [LW-1:0] res_o,
  output logic          sat_o
);
  localparam int unsigned SW = $clog2(LW);
  localparam logic [CW-1:0] LW_C = CW'(LW);
  localparam logic [LW-1:0] MAX_V = {1'b0, {(LW-1){1'b1}}};
  localparam logic [LW-1:0] MIN_V = {1'b1, {(LW-1){1'b0}}};

  logic          neg;
  logic [CW-1:0] mag;
  logic          big;
  logic [SW-1:0] sh;
  logic [2*LW-1:0] lft;
  logic [LW:0]   rnd_sum;
  logic [LW-1:0] rgt;
  logic [LW:0]   lft_top;
  logic          fits;

  always_comb begin
    neg     = cnt_i[CW-1];
    mag     = neg ? (CW'(0) - cnt_i) : cnt_i;   // -128 maps to 128 unsigned
    big     = (mag >= LW_C);
    sh      = mag[SW-1:0];
    lft     = {{LW{val_i[LW-1]}}, val_i} << sh;
    lft_top = lft[2*LW-1:LW-1];
    fits    = (&lft_top) | ~(|lft_top);
    // bias sits one bit under the shift point; sh >= 1 whenever it is used
    rnd_sum = {val_i[LW-1], val_i} + ((LW+1)'(1) << (sh - SW'(1)));
    rgt     = LW'($signed(rnd_sum) >>> sh);

    res_o = '0;
    sat_o = 1'b0;
    if (neg) begin
      res_o = big ? '0 : rgt;
    end else if (val_i == '0) begin
      res_o = '0;
    end else if (big || !fits) begin
      sat_o = 1'b1;
      res_o = val_i[LW-1] ? MIN_V : MAX_V;
    end else begin
      res_o = lft[LW-1:0];
    end
  end
endmodule

// File: rtl/lqs_group.sv
module lqs_group #(
  parameter int unsigned DW = 128,
  parameter int unsigned LW = 8,
  parameter int unsigned CW = 8,
  localparam int unsigned NL = DW / LW
) (
  input  logic [DW-1:0]    val_i,
  input  logic [NL*CW-1:0] cnt_i,
  input  logic [NL-1:0]    act_i,
  output logic [DW-1:0]    res_o,
  output logic             sat_o
);
  logic [NL-1:0] lane_sat;

  for (genvar e = 0; e < NL; e++) begin : g_lane
    lqs_lane #(.LW(LW), .CW(CW)) i_lane (
      .val_i (val_i[e*LW +: LW]),
      .cnt_i (cnt_i[e*CW +: CW]),
      .res_o (res_o[e*LW +: LW]),
      .sat_o (lane_sat[e])
    );
  end

  assign sat_o = |(lane_sat & act_i);
endmodule

// File: rtl/lqs_decode.sv
module lqs_decode
  import lqs_pkg::*;
#(
  parameter int unsigned DW = DATA_W
) (
  input  logic [1:0]    size_i,
  input  logic          wide_i,
  input  logic          scalar_i,
  output logic [DW-1:0] act_mask_o,
  output logic          illegal_o
);
  int unsigned act_w;

  always_comb begin
    illegal_o = !scalar_i && (lane_sz_e'(size_i) == SZ_64) && !wide_i;
    if (scalar_i)    act_w = MIN_LW << size_i;
    else if (wide_i) act_w = DW;
    else             act_w = DW / 2;
    for (int i = 0; i < DW; i++) act_mask_o[i] = (i < act_w);
  end
endmodule

// File: rtl/lane_qrshift.sv
module lane_qrshift
  import lqs_pkg::*;
#(
  parameter int unsigned DW = DATA_W,
  parameter int unsigned CW = CNT_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          valid_i,
  input  logic [DW-1:0] opa_i,
  input  logic [DW-1:0] opb_i,
  input  logic [1:0]    size_i,
  input  logic          wide_i,
  input  logic          scalar_i,
  input  logic          qc_clr_i,
  output logic [DW-1:0] res_o,
  output logic          sat_o,
  output logic          qc_o,
  output logic          illegal_o
);
  logic [DW-1:0]     act_mask;
  logic              bad_enc;
  logic [DW-1:0]     grp_res [NUM_SZ];
  logic [NUM_SZ-1:0] grp_sat;
  logic [DW-1:0]     sel_res;
  logic              sel_sat;

  lqs_decode #(.DW(DW)) i_decode (
    .size_i     (size_i),
    .wide_i     (wide_i),
    .scalar_i   (scalar_i),
    .act_mask_o (act_mask),
    .illegal_o  (bad_enc)
  );

  for (genvar g = 0; g < NUM_SZ; g++) begin : g_sz
    localparam int unsigned LW = MIN_LW << g;
    localparam int unsigned NL = DW / LW;
    logic [NL*CW-1:0] cnt_v;
    logic [NL-1:0]    act_v;

    for (genvar e = 0; e < NL; e++) begin : g_pick
      assign cnt_v[e*CW +: CW] = opb_i[e*LW +: CW];
      assign act_v[e]          = act_mask[e*LW];
    end

    lqs_group #(.DW(DW), .LW(LW), .CW(CW)) i_grp (
      .val_i (opa_i),
      .cnt_i (cnt_v),
      .act_i (act_v),
      .res_o (grp_res[g]),
      .sat_o (grp_sat[g])
    );
  end

  assign sel_res = grp_res[size_i] & act_mask;
  assign sel_sat = grp_sat[size_i] & ~bad_enc;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_o     <= '0;
      sat_o     <= 1'b0;
      illegal_o <= 1'b0;
      qc_o      <= 1'b0;
    end else begin
      if (valid_i) begin
        res_o     <= bad_enc ? '0 : sel_res;
        sat_o     <= sel_sat;
        illegal_o <= bad_enc;
      end
      // a new saturation event outranks a clear in the same cycle
      if (valid_i && sel_sat) qc_o <= 1'b1;
      else if (qc_clr_i)      qc_o <= 1'b0;
    end
  end
endmodule

// File: rtl/lane_qrshift_chk.sv
module lane_qrshift_chk #(
  parameter int unsigned DW = 128
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          valid_i,
  input logic [DW-1:0] opa_i,
  input logic [DW-1:0] opb_i,
  input logic [1:0]    size_i,
  input logic          wide_i,
  input logic          scalar_i,
  input logic          qc_clr_i,
  input logic [DW-1:0] res_o,
  input logic          sat_o,
  input logic          qc_o,
  input logic          illegal_o
);
  localparam int unsigned HW = DW / 2;

  a_r3_illegal_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !scalar_i && size_i == 2'b11 && !wide_i) |=> illegal_o);

  a_r3_illegal_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> (res_o == '0 && !sat_o));

  a_r8_qc_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (qc_o && !qc_clr_i) |=> qc_o);

  a_r8_qc_on_sat: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sat_o) |-> qc_o);

  a_r8_qc_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (qc_clr_i && !valid_i) |=> !qc_o);

  a_r11_upper_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && (scalar_i || !wide_i)) |=> (res_o[DW-1:HW] == '0));

  a_r9_scalar_byte: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && scalar_i && size_i == 2'b00) |=> (res_o[DW-1:8] == '0));

  a_r5_zero_count: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && scalar_i && size_i == 2'b11 && opb_i[7:0] == 8'h00)
      |=> (res_o == {{HW{1'b0}}, $past(opa_i[HW-1:0])} && !sat_o));

  a_r12_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> ($stable(res_o) && $stable(sat_o) && $stable(illegal_o)));
endmodule

bind lane_qrshift lane_qrshift_chk #(.DW(DW)) i_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .valid_i   (valid_i),
  .opa_i     (opa_i),
  .opb_i     (opb_i),
  .size_i    (size_i),
  .wide_i    (wide_i),
  .scalar_i  (scalar_i),
  .qc_clr_i  (qc_clr_i),
  .res_o     (res_o),
  .sat_o     (sat_o),
  .qc_o      (qc_o),
  .illegal_o (illegal_o)
);

// File: tb/test_lane_qrshift.sv
`timescale 1ns/1ps
module test_lane_qrshift;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         valid = 1'b0;
  logic [127:0] opa = '0;
  logic [127:0] opb = '0;
  logic [1:0]   size = '0;
  logic         wide = 1'b0;
  logic         scalar = 1'b0;
  logic         qc_clr = 1'b0;
  logic [127:0] res;
  logic         sat, qc, ill;

  int n_chk = 0;
  int n_bad = 0;
  logic qc_exp = 1'b0;

  always #2.5 clk = ~clk;

  lane_qrshift i_lane_qrshift (
    .clk_i (clk), .rst_ni (rst_n), .valid_i (valid),
    .opa_i (opa), .opb_i (opb), .size_i (size), .wide_i (wide),
    .scalar_i (scalar), .qc_clr_i (qc_clr),
    .res_o (res), .sat_o (sat), .qc_o (qc), .illegal_o (ill)
  );

  task automatic chk_vec(input string req, input string what, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic chk_bit(input string req, input string what, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  // independent arithmetic model at 192-bit precision
  function automatic void model(input logic [127:0] a, input logic [127:0] b, input logic [1:0] sz,
                                input logic wd, input logic sc,
                                output logic [127:0] r, output logic s, output logic il);
    int lw, aw;
    lw = 8 << sz;
    aw = sc ? lw : (wd ? 128 : 64);
    r  = '0;
    s  = 1'b0;
    il = !sc && sz == 2'b11 && !wd;
    if (il) return;
    for (int e = 0; e * lw < aw; e++) begin
      logic [63:0] raw;
      longint x;
      int c;
      logic signed [191:0] v, mx, mn;
      logic [127:0] piece;
      raw = 64'(a >> (e * lw));
      x   = $signed(raw << (64 - lw)) >>> (64 - lw);
      c   = $signed(b[e*lw +: 8]);
      v   = x;
      if (c >= 0) v = v <<< c;
      else begin
        v = v + (192'sd1 <<< (-c - 1));
        v = v >>> (-c);
      end
      mx = (192'sd1 <<< (lw - 1)) - 192'sd1;
      mn = -mx - 192'sd1;
      if (v > mx) begin v = mx; s = 1'b1; end
      if (v < mn) begin v = mn; s = 1'b1; end
      piece = 128'(v[63:0]) & ((128'd1 << lw) - 128'd1);
      r = r | (piece << (e * lw));
    end
  endfunction

  task automatic run_op(input logic [127:0] a, input logic [127:0] b, input logic [1:0] sz,
                        input logic wd, input logic sc, input logic clr, input string req);
    logic [127:0] er;
    logic es, ei;
    model(a, b, sz, wd, sc, er, es, ei);
    @(negedge clk);
    opa = a; opb = b; size = sz; wide = wd; scalar = sc; qc_clr = clr; valid = 1'b1;
    @(negedge clk);
    valid = 1'b0; qc_clr = 1'b0;
    qc_exp = (clr ? 1'b0 : qc_exp) | (es & ~ei);
    chk_vec(req, "res", res, er);
    chk_bit(req, "sat", sat, es);
    chk_bit(req, "illegal", ill, ei);
    chk_bit("R8", "qc", qc, qc_exp);
  endtask

  task automatic t_reset();
    chk_vec("R12", "reset res", res, '0);
    chk_bit("R12", "reset sat", sat, 1'b0);
    chk_bit("R12", "reset qc", qc, 1'b0);
    chk_bit("R12", "reset illegal", ill, 1'b0);
  endtask

  task automatic t_passthru();
    logic [127:0] a;
    a = 128'h8001_7FFE_1234_5678_9ABC_DEF0_0F1E_2D3C;
    for (int s = 0; s < 4; s++) begin
      run_op(a, '0, 2'(s), 1'b1, 1'b0, 1'b0, "R5");
      chk_vec("R5", "zero count passthrough", res, a);
    end
  endtask

  task automatic t_sizes();
    logic [127:0] a, b;
    a = {16{8'h03}};
    b = {8{16'h0002}};
    run_op(a, b, 2'b00, 1'b1, 1'b0, 1'b0, "R1");
    chk_vec("R1", "byte lanes", res, {8{16'h030C}});
    run_op(a, b, 2'b01, 1'b1, 1'b0, 1'b0, "R1");
    chk_vec("R1", "half lanes", res, {8{16'h0C0C}});
    run_op(a, b, 2'b10, 1'b1, 1'b0, 1'b0, "R1");
    run_op(a, b, 2'b11, 1'b1, 1'b0, 1'b0, "R1");
  endtask

  task automatic t_right();
    run_op({96'h0, 32'h07FA_FB05}, {96'h0, 32'hFEFE_FFFF}, 2'b00, 1'b1, 1'b0, 1'b0, "R6");
    chk_vec("R6", "rounded right", res, {96'h0, 32'h02FF_FE03});
    run_op({8{16'h8001}}, {8{16'hFFFF}}, 2'b01, 1'b1, 1'b0, 1'b0, "R6");
    run_op({2{64'hFFFF_FFFF_FFFF_FFFF}}, {2{64'h0000_0000_0000_00FF}}, 2'b11, 1'b1, 1'b0, 1'b0, "R6");
    chk_vec("R6", "minus one ties up", res, '0);
  endtask

  task automatic t_sat();
    run_op({112'h0, 16'h8040}, {112'h0, 16'h0101}, 2'b00, 1'b1, 1'b0, 1'b0, "R7");
    chk_vec("R7", "clamp both ends", res, {112'h0, 16'h807F});
    chk_bit("R7", "sat flag", sat, 1'b1);
    run_op({4{32'h4000_0000}}, {4{32'h0000_0001}}, 2'b10, 1'b1, 1'b0, 1'b1, "R7");
  endtask

  task automatic t_big();
    run_op({64'h0, 64'h1}, {2{64'h7F}}, 2'b11, 1'b1, 1'b0, 1'b0, "R10");
    chk_vec("R10", "huge left", res, {64'h0, 64'h7FFF_FFFF_FFFF_FFFF});
    run_op({64'h7FFF_FFFF_FFFF_FFFF, 64'h8000_0000_0000_0000}, {2{64'h80}}, 2'b11, 1'b1, 1'b0, 1'b0, "R10");
    chk_vec("R10", "huge right", res, '0);
    run_op({4{32'h7FFF_FFFF}}, {32'h20, 32'hE0, 32'h1F, 32'hE1}, 2'b10, 1'b1, 1'b0, 1'b0, "R10");
    run_op({16{8'h00}}, {16{8'h40}}, 2'b00, 1'b1, 1'b0, 1'b1, "R10");
    chk_bit("R10", "zero never saturates", sat, 1'b0);
  endtask

  task automatic t_upper_count();
    logic [127:0] r0;
    run_op({8{16'h0123}}, {8{16'h0002}}, 2'b01, 1'b1, 1'b0, 1'b0, "R4");
    r0 = res;
    run_op({8{16'h0123}}, {8{16'hA502}}, 2'b01, 1'b1, 1'b0, 1'b0, "R4");
    chk_vec("R4", "high count bits ignored", res, r0);
    run_op({2{64'h0000_0000_0000_1000}}, {2{64'hFFFF_FFFF_FFFF_FF04}}, 2'b11, 1'b1, 1'b0, 1'b0, "R4");
  endtask

  task automatic t_width();
    run_op({{8{8'h7F}}, {8{8'h01}}}, {16{8'h01}}, 2'b00, 1'b0, 1'b0, 1'b1, "R11");
    chk_vec("R11", "half width", res, {64'h0, {8{8'h02}}});
    chk_bit("R11", "inactive lanes no sat", sat, 1'b0);
    run_op({16{8'h7F}}, {16{8'h01}}, 2'b00, 1'b1, 1'b0, 1'b0, "R2");
    chk_vec("R2", "full width", res, {16{8'h7F}});
    run_op({4{32'h0001_0000}}, {4{32'h0000_00FC}}, 2'b10, 1'b0, 1'b0, 1'b0, "R2");
  endtask

  task automatic t_scalar();
    run_op({{15{8'h70}}, 8'h21}, {16{8'h01}}, 2'b00, 1'b0, 1'b1, 1'b1, "R9");
    chk_vec("R9", "scalar byte", res, 128'h42);
    chk_bit("R9", "scalar sat", sat, 1'b0);
    run_op({64'h7, 64'h0000_0000_0000_0007}, {64'h0, 64'h0000_0000_0000_00FF}, 2'b11, 1'b0, 1'b1, 1'b0, "R9");
    chk_vec("R9", "scalar 64", res, 128'h4);
    chk_bit("R9", "scalar 64 legal", ill, 1'b0);
  endtask

  task automatic t_illegal();
    run_op({2{64'h4000_0000_0000_0000}}, {2{64'h1}}, 2'b11, 1'b1, 1'b0, 1'b1, "R7");
    chk_bit("R7", "qc set", qc, 1'b1);
    run_op({2{64'h4000_0000_0000_0000}}, {2{64'h1}}, 2'b11, 1'b0, 1'b0, 1'b0, "R3");
    chk_bit("R3", "illegal flag", ill, 1'b1);
    chk_vec("R3", "no data", res, '0);
    chk_bit("R3", "qc kept", qc, 1'b1);
    run_op({16{8'h01}}, '0, 2'b00, 1'b1, 1'b0, 1'b0, "R3");
    chk_bit("R3", "illegal cleared", ill, 1'b0);
  endtask

  task automatic t_qc();
    logic [127:0] held;
    run_op({16{8'h01}}, '0, 2'b00, 1'b1, 1'b0, 1'b1, "R8");
    chk_bit("R8", "clear", qc, 1'b0);
    run_op({16{8'h7F}}, {16{8'h01}}, 2'b00, 1'b1, 1'b0, 1'b1, "R8");
    chk_bit("R8", "set beats clear", qc, 1'b1);
    held = res;
    repeat (3) @(negedge clk);
    chk_vec("R12", "held while idle", res, held);
    chk_bit("R8", "sticky while idle", qc, 1'b1);
    qc_clr = 1'b1;
    @(negedge clk);
    qc_clr = 1'b0;
    qc_exp = 1'b0;
    chk_bit("R8", "standalone clear", qc, 1'b0);
    chk_bit("R12", "sat held", sat, 1'b1);
  endtask

  task automatic t_random();
    for (int i = 0; i < 400; i++) begin
      logic [127:0] a, b;
      a = {$urandom, $urandom, $urandom, $urandom};
      b = {$urandom, $urandom, $urandom, $urandom};
      if (i % 2 == 0)
        for (int k = 0; k < 16; k++) b[k*8 +: 8] = 8'($urandom_range(0, 80)) - 8'd40;
      if (i % 5 == 0) a = a >> $urandom_range(0, 127);
      run_op(a, b, 2'($urandom_range(0, 3)), 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
             ($urandom_range(0, 7) == 0), "R1 random");
    end
  endtask

  initial begin
    #(5.0 * 150000);
    n_bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_passthru();
    t_sizes();
    t_right();
    t_sat();
    t_big();
    t_upper_count();
    t_width();
    t_scalar();
    t_illegal();
    t_qc();
    t_random();
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule